// File: doc/BRIEF.md
# Seeded BCD Watchdog Counter

This block is a software watchdog whose timeout is held as four BCD digits: a seconds byte (00 to 99) and a hundredths byte (00 to 99). The timeout can be set from 0.01 s to 99.99 s in 10 ms steps. A 100 Hz tick input paces the countdown. A seed register keeps the last value software wrote. Every read or write of either count byte puts the seed back into the running counter, so a periodic access by a healthy processor restarts the timeout.

When the count runs down to zero, a sticky expiry flag is set. If the route bit is set, a single-cycle reset request also goes to an external reset pulse generator. With the enable bit clear, the counter never moves and its two bytes are plain storage. Writing all zeros while enabled parks the counter, and it then never expires.

A four-state machine governs the counter. STORE is the idle state while the enable bit is clear. RUN is the active countdown. EXPIRED holds at zero after a timeout. PARKED holds at zero because a zero was loaded. The transitions are:
- any state goes to STORE when enable is clear;
- a count access while enabled goes to RUN if the reloaded value is non-zero, and to PARKED if it is zero;
- STORE goes to RUN or PARKED on the cycle after enable is observed high, depending on whether the count is non-zero;
- RUN goes to EXPIRED on the tick that takes the count from 00.01 to 00.00.

EXPIRED and PARKED are left only through an access or through disabling.

Top module: `wdog_bcd_top`

## Requirements
- R1: After reset, both count bytes, the seed, the control bits and the flag are 0, rd_data is 0x00 and reset_req is 0.
- R2: sel 0 is the hundredths byte and sel 1 is the seconds byte, each two BCD digits with the tens digit in bits 7:4. In sel 2, bit 1 is enable and bit 0 is route; the other bits read 0 and writes to them are ignored. In sel 3, bit 7 is the flag and the other bits read 0. A read returns its byte on rd_data after the clock edge that samples rd_en.
- R3: A write to a count byte replaces that byte of the seed, and the counter is loaded with the whole updated seed in the same cycle.
- R4: A read of a count byte returns the count value from before the read, and the counter is reloaded from the seed.
- R5: In RUN, each sampled tick without an access decrements the count by 0.01 with BCD borrow across all four digits (10.00 becomes 09.99). A tick sampled on the cycle after the enable write is not yet counted.
- R6: The tick that reaches 00.00 sets the flag. The count then stays at 00.00 (no wrap) until the next access.
- R7: On expiry with route=1, reset_req is high for exactly one cycle, in the same cycle the flag becomes visible. With route=0, reset_req stays low.
- R8: Loading 00.00 while enabled parks the counter, and the flag is never set by it.
- R9: With enable=0, ticks are ignored and the count bytes read back exactly what was written.
- R10: Writing sel 3 with bit 7 = 0 clears the flag. Writing bit 7 = 1 leaves it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R11: A count access before the count reaches zero restarts it from the seed and prevents expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle 100 Hz pacing pulse |
| sel | input | 2 | Register select (0 hundredths, 1 seconds, 2 control, 3 status) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| reset_req | output | 1 | One-cycle request to the reset pulse generator |

## Verification
The hardest condition to reach from the ports is a clear of the flag in the very cycle that a tick takes the count from 00.01 to 00.00. The bench gets there by loading 00.01 and then issuing the tick and the status write in the same cycle. Expiry needs a read or write to be absent on the deciding tick, but every read of the count reloads it. For that reason the bench watches reset_req and the status byte instead of polling the count. A behavioural model in decimal integers is compared with rd_data and reset_req on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        ST_STORE,
        ST_RUN,
        ST_EXPIRED,
        ST_PARKED
    } wd_state_e;

    localparam logic [1:0] SEL_CNT_LO = 2'd0;
    localparam logic [1:0] SEL_CNT_HI = 2'd1;
    localparam logic [1:0] SEL_CTRL   = 2'd2;
    localparam logic [1:0] SEL_STAT   = 2'd3;

    localparam int CTRL_EN_BIT    = 1;
    localparam int CTRL_ROUTE_BIT = 0;
    localparam int STAT_FLAG_BIT  = 7;
endpackage

// File: rtl/wdog_bcd_digit.sv
module wdog_bcd_digit (
    input  logic [3:0] d,
    input  logic       borrow_in,
    output logic [3:0] q,
    output logic       borrow_out
);
    always_comb begin
        if (!borrow_in) begin
            q = d;
        end else if (d == 4'd0) begin
            q = 4'd9;
        end else begin
            q = d - 4'd1;
        end
        borrow_out = borrow_in && (d == 4'd0);
    end
endmodule

// File: rtl/wdog_bcd_dec.sv
module wdog_bcd_dec #(
    parameter int DIGITS = 4
) (
    input  logic [DIGITS*4-1:0] val,
    output logic [DIGITS*4-1:0] dec,
    output logic                is_zero,
    output logic                dec_is_zero
);
    localparam int W = DIGITS * 4;

    logic [DIGITS:0] borrow;
    assign borrow[0] = 1'b1;

    genvar g;
    generate
        for (g = 0; g < DIGITS; g++) begin : g_digit
            wdog_bcd_digit u_digit (
                .d          (val[g*4 +: 4]),
                .borrow_in  (borrow[g]),
                .q          (dec[g*4 +: 4]),
                .borrow_out (borrow[g+1])
            );
        end
    endgenerate

    assign is_zero     = (val == {W{1'b0}});
    assign dec_is_zero = (dec == {W{1'b0}});

    // every digit of a non-zero BCD input must stay a valid BCD digit after decrement (R5)
    always_comb begin
        for (int k = 0; k < DIGITS; k++) begin
            if (!is_zero && (val[k*4 +: 4] <= 4'd9)) begin
                assert_digit_valid_R5: assert (dec[k*4 +: 4] <= 4'd9);
            end
        end
    end
endmodule

// File: rtl/wdog_ctrl_fsm.sv
module wdog_ctrl_fsm
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      access,
    input  logic      load_zero,
    input  logic      cnt_zero,
    input  logic      dec_zero,
    input  logic      tick,
    output wd_state_e state,
    output logic      dec_en,
    output logic      expire
);
    wd_state_e state_d;

    always_comb begin
        state_d = state;
        if (!en) begin
            state_d = ST_STORE;
        end else if (access) begin
            state_d = load_zero ? ST_PARKED : ST_RUN;
        end else begin
            unique case (state)
                ST_STORE:   state_d = cnt_zero ? ST_PARKED : ST_RUN;
                ST_RUN:     state_d = (tick && dec_zero) ? ST_EXPIRED : ST_RUN;
                ST_EXPIRED: state_d = ST_EXPIRED;
                ST_PARKED:  state_d = ST_PARKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_STORE;
        end else begin
            state <= state_d;
        end
    end

    always_comb begin
        dec_en = 1'b0;
        expire = 1'b0;
        unique case (state)
            ST_RUN: begin
                dec_en = en && tick && !access;
                expire = en && tick && !access && dec_zero;
            end
            ST_STORE, ST_EXPIRED, ST_PARKED: begin
                dec_en = 1'b0;
                expire = 1'b0;
            end
        endcase
    end

    assert_hold_states_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXPIRED || state == ST_PARKED) |-> cnt_zero);

    assert_disable_to_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_STORE));

    assert_run_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> !cnt_zero);
endmodule

// File: rtl/wdog_bcd_top.sv
module wdog_bcd_top
    import wdog_pkg::*;
#(
    parameter int DIGITS = 4,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              reset_req
);
    localparam int CNT_W = DIGITS * 4;

    logic [CNT_W-1:0]  cnt_q, seed_q, seed_d, cnt_dec;
    logic              en_q, route_q, flag_q, rst_q;
    logic [BYTE_W-1:0] rd_q;
    logic              cnt_sel, cnt_acc, cnt_wr;
    logic              cnt_zero, dec_zero, load_zero;
    logic              dec_en, expire;
    wd_state_e         state;

    assign cnt_sel = (sel == SEL_CNT_LO) || (sel == SEL_CNT_HI);
    assign cnt_acc = (wr_en || rd_en) && cnt_sel;
    assign cnt_wr  = wr_en && cnt_sel;

    always_comb begin
        seed_d = seed_q;
        if (cnt_wr) begin
            seed_d[sel[0]*BYTE_W +: BYTE_W] = wr_data;
        end
    end
    assign load_zero = (seed_d == {CNT_W{1'b0}});

    wdog_bcd_dec #(.DIGITS(DIGITS)) u_dec (
        .val         (cnt_q),
        .dec         (cnt_dec),
        .is_zero     (cnt_zero),
        .dec_is_zero (dec_zero)
    );

    wdog_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_q),
        .access    (cnt_acc),
        .load_zero (load_zero),
        .cnt_zero  (cnt_zero),
        .dec_zero  (dec_zero),
        .tick      (tick),
        .state     (state),
        .dec_en    (dec_en),
        .expire    (expire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seed_q <= '0;
        end else begin
            seed_q <= seed_d;
            if (cnt_acc) begin
                cnt_q <= seed_d;
            end else if (dec_en) begin
                cnt_q <= cnt_dec;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            route_q <= 1'b0;
            flag_q  <= 1'b0;
            rst_q   <= 1'b0;
        end else begin
            if (wr_en && sel == SEL_CTRL) begin
                en_q    <= wr_data[CTRL_EN_BIT];
                route_q <= wr_data[CTRL_ROUTE_BIT];
            end
            if (expire) begin
                flag_q <= 1'b1;
            end else if (wr_en && sel == SEL_STAT && !wr_data[STAT_FLAG_BIT]) begin
                flag_q <= 1'b0;
            end
            rst_q <= expire && route_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= '0;
            unique case (sel)
                SEL_CNT_LO: rd_q <= cnt_q[0 +: BYTE_W];
                SEL_CNT_HI: rd_q <= cnt_q[BYTE_W +: BYTE_W];
                SEL_CTRL: begin
                    rd_q[CTRL_EN_BIT]    <= en_q;
                    rd_q[CTRL_ROUTE_BIT] <= route_q;
                end
                SEL_STAT: rd_q[STAT_FLAG_BIT] <= flag_q;
            endcase
        end
    end

    assign rd_data   = rd_q;
    assign reset_req = rst_q;

    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_zero && !cnt_acc) |=> (cnt_q == '0));

    assert_req_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    assert_req_has_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> flag_q);

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_en && sel == SEL_STAT && !wr_data[STAT_FLAG_BIT])) |=> flag_q);

    assert_tick_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && en_q && tick && !cnt_acc) |=> (cnt_q != $past(cnt_q)));

    assert_idle_ignores_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !cnt_acc) |=> $stable(cnt_q));
endmodule

// File: tb/test_wdog_bcd_top.sv
module test_wdog_bcd_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       reset_req;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    pulses  = 0;
    string cur_req = "R1";

    // reference model state (decimal)
    int       m_cnt, m_seed, m_st;
    bit       m_en, m_route, m_flag, m_rst;
    bit [7:0] m_rd;

    wdog_bcd_top i_wdog_bcd_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .sel       (sel),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .reset_req (reset_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit [7:0] to_bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int from_bcd(bit [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    // behavioural model: 0 idle, 1 counting, 2 timed out, 3 parked
    always @(posedge clk) begin
        bit acc, run, expd;
        int nseed, nst;
        if (!rst_n) begin
            m_cnt = 0; m_seed = 0; m_st = 0; m_en = 0; m_route = 0;
            m_flag = 0; m_rst = 0; m_rd = 0;
        end else begin
            acc  = (wr_en || rd_en) && (sel < 2);
            run  = (m_st == 1) && m_en && tick && !acc;
            expd = run && (m_cnt == 1);
            nseed = m_seed;
            if (wr_en && sel == 0) nseed = (m_seed / 100) * 100 + from_bcd(wr_data);
            if (wr_en && sel == 1) nseed = from_bcd(wr_data) * 100 + (m_seed % 100);
            if (rd_en) begin
                case (sel)
                    2'd0: m_rd = to_bcd(m_cnt % 100);
                    2'd1: m_rd = to_bcd(m_cnt / 100);
                    2'd2: m_rd = {6'b0, m_en, m_route};
                    default: m_rd = {m_flag, 7'b0};
                endcase
            end
            if (!m_en) nst = 0;
            else if (acc) nst = (nseed == 0) ? 3 : 1;
            else if (m_st == 0) nst = (m_cnt == 0) ? 3 : 1;
            else if (m_st == 1) nst = expd ? 2 : 1;
            else nst = m_st;
            m_rst = expd && m_route;
            if (acc) m_cnt = nseed;
            else if (run) m_cnt = m_cnt - 1;
            m_seed = nseed;
            if (wr_en && sel == 2) begin
                m_en = wr_data[1];
                m_route = wr_data[0];
            end
            if (wr_en && sel == 3 && !wr_data[7]) m_flag = 0;
            if (expd) m_flag = 1;
            m_st = nst;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        n_tests++;
        if (rd_data !== m_rd || reset_req !== m_rst) begin
            n_fail++;
            $display("FAIL %s: rd_data=%h reset_req=%b expected rd_data=%h reset_req=%b",
                     cur_req, rd_data, reset_req, m_rd, m_rst);
        end
        if (reset_req === 1'b1) pulses++;
    end

    task automatic op(input bit w, input bit r, input bit [1:0] s, input bit [7:0] d, input bit t);
        @(negedge clk);
        wr_en = w; rd_en = r; sel = s; wr_data = d; tick = t;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(0, 0, 2'd0, 8'h00, 0);
    endtask

    task automatic wr(input bit [1:0] s, input bit [7:0] d);
        op(1, 0, s, d, 0);
    endtask

    task automatic rd(input bit [1:0] s);
        op(0, 1, s, 8'h00, 0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            op(0, 0, 2'd0, 8'h00, 1);
            op(0, 0, 2'd0, 8'h00, 0);
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        cur_req = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(2);
        rd(0); rd(1); rd(2); rd(3); idle(1);

        cur_req = "R2";
        wr(2, 8'hFF); rd(2); wr(2, 8'h00); rd(2); rd(3); idle(1);

        cur_req = "R9";
        wr(0, 8'h34); wr(1, 8'h12); ticks(10); rd(0); rd(1); idle(1);

        cur_req = "R3";
        wr(1, 8'h56); rd(0); rd(1); idle(1);

        cur_req = "R5";
        wr(0, 8'h00); wr(1, 8'h10); wr(2, 8'h02); ticks(3); rd(0); rd(1); idle(1);
        ticks(2); rd(1); idle(1);

        cur_req = "R4";
        ticks(4); rd(0); rd(0); idle(1);

        cur_req = "R11";
        wr(1, 8'h00); wr(0, 8'h03);
        for (int k = 0; k < 5; k++) begin
            ticks(2);
            rd(1);
        end
        rd(3); idle(1);

        cur_req = "R6";
        pulses = 0;
        ticks(6); rd(3); wr(2, 8'h00); rd(0); rd(1); idle(1);
        check("R7", pulses, 0);

        cur_req = "R10";
        wr(3, 8'h80); rd(3); wr(3, 8'h00); rd(3); idle(1);

        cur_req = "R7";
        pulses = 0;
        wr(2, 8'h03); wr(1, 8'h00); wr(0, 8'h02); ticks(4); rd(3); idle(2);
        check("R7", pulses, 1);

        cur_req = "R10";
        wr(2, 8'h00); wr(3, 8'h00); wr(0, 8'h01); wr(2, 8'h02); idle(2);
        op(1, 0, 2'd3, 8'h00, 1); idle(1); rd(3); idle(1);

        cur_req = "R8";
        wr(3, 8'h00); wr(0, 8'h00); wr(1, 8'h00); ticks(8); rd(3); rd(0); idle(2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule